// File: doc/BRIEF.md
# Cache Invalidation Sequencer

This block clears valid bits in the tag memory of a write-through cache when software writes a cache-control CSR. Every accepted write starts an invalidation. The top bit of the written word selects the kind. With the bit set, the block clears one line, chosen by the index in the low bits. With the bit clear, it sweeps every line in turn, using an internal counter. A write of zero therefore still means "flush everything", so older software that wrote the zero register keeps working.

While an invalidation is running, the block takes the tag RAM write port away from the cache's own write request. It writes a cleared valid bit at the index being invalidated. When it is idle, the cache's request passes straight through. The cache is write-through, so nothing is ever written back: invalidation only clears valid bits. The pipeline watches `busy` to hold cache accesses during a sweep. The one-cycle `done` pulse marks the cycle in which the last line is cleared.

Top module: `cinv_seq`

## Requirements
- R1: During and after synchronous active-high reset, with no CSR write and no cache write request, `busy`, `done` and `tag_we` are all 0.
- R2: A CSR write (`csr_we`=1 at a clock edge) accepted while idle makes `busy` 1 from the next cycle on.
- R3: When bit 31 of the written word is 1, the block performs exactly one tag write in the cycle after the CSR write, at index `csr_wdata[7:0]`. `busy` and `done` are 1 in that cycle only.
- R4: In single-line mode, bits 30 to 8 of the written word have no effect on the index or on the timing.
- R5: When bit 31 is 0, the block clears the lines in ascending order, from index 0 to 255, one per cycle. This takes 256 consecutive busy cycles starting the cycle after the write. Bits 30 to 0 are ignored.
- R6: Writing the value 0 starts a full 256-line sweep.
- R7: `done` is 1 for exactly one cycle per invalidation, in the cycle of the last tag write. `busy` is 0 in the cycle after `done`.
- R8: A CSR write sampled while `busy` is 1 is ignored. It neither restarts nor extends the current invalidation, and it does not change its index sequence.
- R9: While `busy` is 1, the block drives the tag port itself: `tag_we`=1, `tag_wvalid`=0 and `tag_idx` is the line being cleared, whatever the cache requests. While idle, `tag_we`, `tag_idx` and `tag_wvalid` follow `cache_we`, `cache_idx` and `cache_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Cache-control CSR write strobe |
| csr_wdata | input | 32 | Written value; bit 31 selects single line, bits 7:0 give the line |
| cache_we | input | 1 | Cache's own tag write request (refill path) |
| cache_idx | input | 8 | Index of the cache's tag write |
| cache_valid | input | 1 | Valid bit of the cache's tag write |
| busy | output | 1 | Invalidation in progress |
| done | output | 1 | One-cycle pulse on the last cleared line |
| tag_we | output | 1 | Tag RAM write enable |
| tag_idx | output | 8 | Tag RAM write index |
| tag_wvalid | output | 1 | Valid bit written into the tag RAM |

## Verification
The bench targets the following corner cases:

- **High index bits set in single-line mode.** The bench writes a single-line command with bits 30 to 8 also set. A decoder that took a wider field would then clear the wrong line.
- **Zero and nonzero sweep words.** The bench issues a zero write and a nonzero write with bit 31 clear. A sweep that started from the written bits, or skipped or repeated a line, would break the ascending 0 to 255 order. A counter with an off-by-one terminal test would give the wrong busy length.
- **Writes during a sweep.** The bench writes mid-sweep and again exactly in the `done` cycle. A design that accepted these writes would restart the sweep or extend `busy`.
- **Competing cache writes.** The bench asserts cache write requests during a sweep. Missing port ownership would then let a valid bit of 1 reach the tag RAM.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

    localparam int CSR_W    = 32;
    localparam int MODE_BIT = 31;

    typedef enum logic {
        MODE_SWEEP = 1'b0,
        MODE_LINE  = 1'b1
    } inv_mode_e;

    typedef struct packed {
        logic      active;
        inv_mode_e mode;
    } seq_state_t;

    function automatic inv_mode_e mode_of(input logic [CSR_W-1:0] word);
        return word[MODE_BIT] ? MODE_LINE : MODE_SWEEP;
    endfunction

endpackage

// File: rtl/cinv_cmd_decode.sv
module cinv_cmd_decode
    import cinv_pkg::*;
#(
    parameter int LINES = 256,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             busy,
    output logic             start,
    output inv_mode_e        mode,
    output logic [IDX_W-1:0] line_idx
);

    logic unused_hi_bits;

    always_comb begin
        start          = csr_we && !busy;
        mode           = mode_of(csr_wdata);
        line_idx       = csr_wdata[IDX_W-1:0];
        unused_hi_bits = ^csr_wdata[MODE_BIT-1:IDX_W];
    end

endmodule

// File: rtl/cinv_line_ctr.sv
module cinv_line_ctr
    import cinv_pkg::*;
#(
    parameter int LINES = 256,
    localparam int IDX_W = $clog2(LINES),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  inv_mode_e        mode,
    input  logic [IDX_W-1:0] line_idx,
    output logic             active,
    output logic             last,
    output logic [IDX_W-1:0] cur_idx
);

    seq_state_t       st_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{active: 1'b0, mode: MODE_SWEEP};
            idx_q <= '0;
        end else if (st_q.active) begin
            if (last) begin
                st_q.active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (start) begin
            st_q.active <= 1'b1;
            st_q.mode   <= mode;
            idx_q       <= (mode == MODE_LINE) ? line_idx : '0;
        end
    end

    always_comb begin
        active  = st_q.active;
        cur_idx = idx_q;
        last    = st_q.active &&
                  ((st_q.mode == MODE_LINE) || (idx_q == LAST_IDX));
    end

    // R5
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && st_q.mode == MODE_SWEEP && !last) |=> (active && cur_idx == $past(cur_idx) + 1'b1));

    // R5
    sweep_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_SWEEP) |=> (cur_idx == '0));

    // R3
    line_once_chk: assert property (@(posedge clk) disable iff (rst)
        (active && st_q.mode == MODE_LINE) |=> !active);

    // R3
    line_index_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_LINE) |=> (cur_idx == $past(line_idx)));

endmodule

// File: rtl/cinv_tag_mux.sv
module cinv_tag_mux #(
    parameter int LINES = 256,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             active,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             cache_we,
    input  logic [IDX_W-1:0] cache_idx,
    input  logic             cache_valid,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_idx,
    output logic             tag_wvalid
);

    always_comb begin
        if (active) begin
            tag_we     = 1'b1;
            tag_idx    = cur_idx;
            tag_wvalid = 1'b0;
        end else begin
            tag_we     = cache_we;
            tag_idx    = cache_idx;
            tag_wvalid = cache_valid;
        end
    end

endmodule

// File: rtl/cinv_seq.sv
module cinv_seq
    import cinv_pkg::*;
#(
    parameter int LINES = 256,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic             cache_we,
    input  logic [IDX_W-1:0] cache_idx,
    input  logic             cache_valid,
    output logic             busy,
    output logic             done,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_idx,
    output logic             tag_wvalid
);

    logic             start;
    inv_mode_e        cmd_mode;
    logic [IDX_W-1:0] cmd_idx;
    logic             active;
    logic             last;
    logic [IDX_W-1:0] cur_idx;

    cinv_cmd_decode #(.LINES(LINES)) dec_i (
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .busy      (busy),
        .start     (start),
        .mode      (cmd_mode),
        .line_idx  (cmd_idx)
    );

    cinv_line_ctr #(.LINES(LINES)) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (cmd_mode),
        .line_idx (cmd_idx),
        .active   (active),
        .last     (last),
        .cur_idx  (cur_idx)
    );

    cinv_tag_mux #(.LINES(LINES)) mux_i (
        .active      (active),
        .cur_idx     (cur_idx),
        .cache_we    (cache_we),
        .cache_idx   (cache_idx),
        .cache_valid (cache_valid),
        .tag_we      (tag_we),
        .tag_idx     (tag_idx),
        .tag_wvalid  (tag_wvalid)
    );

    always_comb begin
        busy = active;
        done = last;
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !busy) |=> busy);

    // R7
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    // R8
    ignore_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && csr_we) |=> busy);

    // R9
    port_owned_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tag_we && !tag_wvalid));

endmodule

// File: tb/cinv_seq_tb.sv
module cinv_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        cache_we = 1'b0;
    logic [7:0]  cache_idx = '0;
    logic        cache_valid = 1'b0;
    logic        busy, done, tag_we, tag_wvalid;
    logic [7:0]  tag_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_tag = "R1";

    int m_active = 0;
    int m_line   = 0;
    int m_idx    = 0;
    int busy_cnt = 0;
    int done_cnt = 0;
    int order_bad = 0;
    int prev_idx = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cinv_seq #(.LINES(LINES)) dut_i (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .cache_we(cache_we), .cache_idx(cache_idx), .cache_valid(cache_valid),
        .busy(busy), .done(done), .tag_we(tag_we), .tag_idx(tag_idx),
        .tag_wvalid(tag_wvalid)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
        end
    endtask

    function automatic bit model_last();
        return (m_active != 0) && (m_line != 0 || m_idx == LINES - 1);
    endfunction

    task automatic compare();
        int e_busy, e_done, e_we, e_idx, e_val;
        e_busy = m_active;
        e_done = model_last() ? 1 : 0;
        e_we   = m_active ? 1 : int'(cache_we);
        e_idx  = m_active ? m_idx : int'(cache_idx);
        e_val  = m_active ? 0 : int'(cache_valid);
        check(busy == e_busy, "busy", busy, e_busy);
        check(done == e_done, "done", done, e_done);
        check(tag_we == e_we, "tag_we", tag_we, e_we);
        check(int'(tag_idx) == e_idx, "tag_idx", tag_idx, e_idx);
        check(tag_wvalid == e_val, "tag_wvalid", tag_wvalid, e_val);
        if (busy) begin
            busy_cnt++;
            if (m_line == 0) begin
                if (int'(tag_idx) != prev_idx + 1) order_bad++;
                prev_idx = tag_idx;
            end
        end
        if (done) done_cnt++;
    endtask

    task automatic model_edge(input bit we, input logic [31:0] d);
        if (rst) begin
            m_active = 0; m_line = 0; m_idx = 0;
        end else if (m_active != 0) begin
            if (model_last()) m_active = 0;
            else m_idx++;
        end else if (we) begin
            m_active = 1;
            m_line   = d[31] ? 1 : 0;
            m_idx    = d[31] ? int'(d[7:0]) : 0;
        end
    endtask

    task automatic step(input bit we, input logic [31:0] d,
                        input bit cwe, input logic [7:0] cidx, input bit cval);
        csr_we = we; csr_wdata = d;
        cache_we = cwe; cache_idx = cidx; cache_valid = cval;
        @(posedge clk);
        model_edge(we, d);
        @(negedge clk);
        compare();
    endtask

    task automatic clr_counts();
        busy_cnt = 0; done_cnt = 0; order_bad = 0; prev_idx = -1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset
        cur_tag = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(0, 32'h0, 0, 8'h0, 0);
        rst = 1'b0;
        step(0, 32'h0, 0, 8'h0, 0);

        // R3: single line at index 5
        cur_tag = "R3";
        clr_counts();
        step(1, 32'h8000_0005, 0, 8'h0, 0);
        step(0, 32'h0, 0, 8'h0, 0);
        check(busy_cnt == 1, "R3 busy cycles", busy_cnt, 1);

        // R4: upper bits ignored in single-line mode
        cur_tag = "R4";
        clr_counts();
        step(1, 32'hFFFF_FF80, 0, 8'h0, 0);
        step(0, 32'h0, 0, 8'h0, 0);
        check(busy_cnt == 1 && done_cnt == 1, "R4 one-cycle op", busy_cnt, 1);

        // R9: idle pass-through
        cur_tag = "R9";
        step(0, 32'h0, 1, 8'h33, 1);
        step(0, 32'h0, 1, 8'hC4, 0);

        // R6: zero write gives full sweep, R8/R9 stimulus during it
        cur_tag = "R6";
        clr_counts();
        step(1, 32'h0, 0, 8'h0, 0);
        for (int i = 0; i < 300 && m_active != 0; i++) begin
            if (i == 50) begin
                cur_tag = "R8";
                step(1, 32'h8000_0010, 0, 8'h0, 0);
                cur_tag = "R6";
            end else if (i > 100 && i < 110) begin
                cur_tag = "R9";
                step(0, 32'h0, 1, 8'h07, 1);
                cur_tag = "R6";
            end else begin
                step(0, 32'h0, 0, 8'h0, 0);
            end
        end
        step(0, 32'h0, 0, 8'h0, 0);
        cur_tag = "R5";
        check(busy_cnt == LINES, "R5 sweep busy cycles", busy_cnt, LINES);
        check(order_bad == 0, "R5 ascending order errors", order_bad, 0);
        cur_tag = "R7";
        check(done_cnt == 1, "R7 done pulses", done_cnt, 1);

        // R5: nonzero word with bit 31 clear; R8 write in done cycle
        cur_tag = "R5";
        clr_counts();
        step(1, 32'h0000_00AB, 0, 8'h0, 0);
        while (m_active != 0 && !model_last()) step(0, 32'h0, 0, 8'h0, 0);
        cur_tag = "R8";
        step(1, 32'h8000_0001, 0, 8'h0, 0);
        step(0, 32'h0, 0, 8'h0, 0);
        check(busy_cnt == LINES, "R8 busy not extended", busy_cnt, LINES);
        check(order_bad == 0, "R5 order from zero", order_bad, 0);

        // R2: write right after idle is accepted
        cur_tag = "R2";
        clr_counts();
        step(1, 32'h8000_00FF, 0, 8'h0, 0);
        step(0, 32'h0, 0, 8'h0, 0);
        check(busy_cnt == 1, "R2 accepted after idle", busy_cnt, 1);

        cur_tag = "R7";
        for (int i = 0; i < 3; i++) step(0, 32'h0, 0, 8'h0, 0);
        finish_run();
    end

endmodule